// File: doc/BRIEF.md
# Bistable Passive-Matrix Panel Scan Sequencer

This block generates every control waveform for a passive-matrix bistable LCD with no built-in controller, whose glass carries only a cascaded common (row) driver chain and segment (column) driver chips. For each row it fetches one line of pixel words from an external line buffer and clocks them into the segment drivers over a narrow data bus. It then fires a column-load strobe and, after a programmable gap, a separate row-step strobe that advances the common driver. The frame-start strobe coincides with the first row step. The polarity output keeps the panel on AC drive, and an active-low display-off output gates the drivers' outputs.

The host writes an update as a row band. The common driver can only be reset to row 0, so the sequencer steps it quickly through the rows above the band. For those rows it sends no data clocks and no column loads, and the data lines stay at zero. It then writes rows from the top of the band to the bottom. A bistable panel keeps the image on rows that are not rewritten, so a band update costs far less time than a full-panel pass.

Top module: `lcd_scan_gen`

## Requirements
- R1: After reset, busy_o, done_o, lcd_off_no, lcd_dclk_o, lcd_fstart_o, lcd_col_load_o, lcd_row_step_o, lcd_pol_o and lcd_data_o are all low.
- R2: start_i is taken only while busy_o is low. It captures all configuration inputs, and row_last_i above ROWS-1 is clamped to ROWS-1. A start_i pulse while busy_o is high changes nothing and leaves no update pending after done_o.
- R3: For each band row r, exactly COLS/BUS_W data clocks occur. Word k (k counted from 0) is the buffer value read at buf_row_o = r, buf_addr_o = k. Data changes only while lcd_dclk_o is low and is stable across the rising edge, where the panel samples it.
- R4: Rows below row_first_i get no data clock and no column load, and lcd_data_o is zero throughout those rows.
- R5: The column-load pulse rises exactly t_setup_i cycles after the last data clock of its row falls.
- R6: Column-load and row-step pulses are max(t_lpw_i,1) cycles wide. A row step rises max(t_gap_i,1) cycles after the preceding column load falls, or after the preceding row step falls on rows below the band. The two strobes are never high together.
- R7: lcd_fstart_o is high exactly during the row step of row 0 and never otherwise, once per update.
- R8: An update issues last+1 row steps (last after clamping) and one column load per row in [first, last].
- R9: busy_o stays high for exactly (blank rows)·(g+w) + (band rows)·(2·COLS/BUS_W + t_setup_i + 1 + 2w + g) cycles, with w = max(t_lpw_i,1) and g = max(t_gap_i,1). done_o is a single-cycle pulse in the first cycle busy_o is low.
- R10: With line_inv_i low at start, lcd_pol_o toggles once per update, at completion. With line_inv_i high, it toggles at the end of every row step.
- R11: lcd_off_no is low while idle. During an update it equals the disp_en_i value captured at start, and it returns low together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Update request |
| row_first_i | input | ROW_W | First row of the band |
| row_last_i | input | ROW_W | Last row of the band (clamped) |
| disp_en_i | input | 1 | Enable panel outputs during the update |
| line_inv_i | input | 1 | 1: polarity flips every row, 0: once per update |
| t_setup_i | input | TW | Last data clock fall to column load rise, cycles |
| t_gap_i | input | TW | Column load fall to row step rise, cycles |
| t_lpw_i | input | TW | Strobe pulse width, cycles |
| buf_row_o | output | ROW_W | Row being fetched |
| buf_addr_o | output | ADDR_W | Word index within the row |
| buf_rd_o | output | 1 | Read strobe for the line buffer |
| buf_data_i | input | BUS_W | Word returned in the same cycle |
| lcd_data_o | output | BUS_W | Segment data bus |
| lcd_dclk_o | output | 1 | Segment data clock |
| lcd_fstart_o | output | 1 | Frame start to common driver |
| lcd_col_load_o | output | 1 | Segment latch strobe |
| lcd_row_step_o | output | 1 | Common shift strobe |
| lcd_pol_o | output | 1 | Drive polarity |
| lcd_off_no | output | 1 | Display off, active low |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after zero-valued timing settings, where the column load could coincide with the last data clock fall or a pulse could collapse to no cycles. A design that mishandled zero would give a wrong busy duration or zero-width strobes. It also covers bands that start at row 0 (the frame start then coincides with a band row), bands with first above last (every row blank), a band ending at the last row, and an over-range last row. An off-by-one row counter shows up there as a wrong row-step count or a data-clocked blank row. A start injected mid-update must not cause a second pass, and each polarity mode must leave lcd_pol_o at the parity its toggle count predicts.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SHIFT = 3'd1,
    ST_SETUP = 3'd2,
    ST_COLLD = 3'd3,
    ST_GAP   = 3'd4,
    ST_ROWST = 3'd5
  } scan_st_e;
endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] limit_i,
  output logic          end_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (CW+1)'(1);
  // limit 0 behaves as 1
  assign end_o   = cnt_nxt >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_word_shifter.sv
module lcd_word_shifter #(
  parameter int BUS_W  = 4,
  parameter int WORDS  = 90,
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rd_o,
  input  logic [BUS_W-1:0]  buf_data_i,
  output logic [BUS_W-1:0]  data_o,
  output logic              dclk_o,
  output logic              last_o
);
  localparam logic [ADDR_W-1:0] W_LAST = ADDR_W'(WORDS - 1);

  logic [ADDR_W-1:0] w_q;
  logic              h_q;
  logic              dclk_q;
  logic [BUS_W-1:0]  data_q;

  // two cycles per word: h=0 fetch+load data, h=1 raise clock at next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q    <= '0;
      h_q    <= 1'b0;
      dclk_q <= 1'b0;
      data_q <= '0;
    end else if (!run_i) begin
      w_q    <= '0;
      h_q    <= 1'b0;
      dclk_q <= 1'b0;
      data_q <= '0;
    end else begin
      h_q    <= ~h_q;
      dclk_q <= h_q;
      if (h_q) w_q <= (w_q == W_LAST) ? '0 : w_q + 1'b1;
      else     data_q <= buf_data_i;
    end
  end

  assign buf_addr_o = w_q;
  assign buf_rd_o   = run_i & ~h_q;
  assign data_o     = data_q;
  assign dclk_o     = dclk_q;
  assign last_o     = run_i & h_q & (w_q == W_LAST);
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq
  import lcd_scan_pkg::*;
#(
  parameter int ROWS  = 480,
  parameter int ROW_W = 9,
  parameter int TW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_first_i,
  input  logic [ROW_W-1:0] row_last_i,
  input  logic             disp_en_i,
  input  logic             line_inv_i,
  input  logic [TW-1:0]    t_setup_i,
  input  logic [TW-1:0]    t_gap_i,
  input  logic [TW-1:0]    t_lpw_i,
  input  logic             shift_last_i,
  output logic             run_o,
  output logic [ROW_W-1:0] row_o,
  output logic             fstart_o,
  output logic             col_load_o,
  output logic             row_step_o,
  output logic             pol_o,
  output logic             off_no_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int CW = TW + 1;
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);

  scan_st_e         st_q, st_d;
  logic [ROW_W-1:0] row_q, row_d, row_nxt, first_q, last_q, last_clamp;
  logic [TW-1:0]    ts_q, tg_q, tw_q;
  logic             line_q, en_q, accept;
  logic             tmr_end, tmr_clr;
  logic [CW-1:0]    tmr_lim;
  logic             col_q, rstep_q, fs_q, pol_q, off_q, done_q;
  logic             fin, rstep_end;

  assign accept     = (st_q == ST_IDLE) && start_i;
  assign last_clamp = (row_last_i > ROW_MAX) ? ROW_MAX : row_last_i;
  assign row_nxt    = row_q + 1'b1;

  always_comb begin
    case (st_q)
      ST_SETUP:          tmr_lim = {1'b0, ts_q} + CW'(1);
      ST_COLLD, ST_ROWST: tmr_lim = {1'b0, tw_q};
      ST_GAP:            tmr_lim = {1'b0, tg_q};
      default:           tmr_lim = '0;
    endcase
  end

  always_comb begin
    st_d  = st_q;
    row_d = row_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        row_d = '0;
        st_d  = (row_first_i != '0) ? ST_GAP : ST_SHIFT;
      end
      ST_SHIFT: if (shift_last_i) st_d = ST_SETUP;
      ST_SETUP: if (tmr_end) st_d = ST_COLLD;
      ST_COLLD: if (tmr_end) st_d = ST_GAP;
      ST_GAP:   if (tmr_end) st_d = ST_ROWST;
      ST_ROWST: if (tmr_end) begin
        if (row_q == last_q) st_d = ST_IDLE;
        else begin
          row_d = row_nxt;
          st_d  = (row_nxt < first_q) ? ST_GAP : ST_SHIFT;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign tmr_clr   = (st_d != st_q) || (st_q == ST_IDLE);
  assign fin       = (st_q != ST_IDLE) && (st_d == ST_IDLE);
  assign rstep_end = (st_q == ST_ROWST) && (st_d != ST_ROWST);

  lcd_phase_timer #(.CW(CW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (tmr_clr),
    .limit_i (tmr_lim),
    .end_o   (tmr_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      row_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      ts_q    <= '0;
      tg_q    <= '0;
      tw_q    <= '0;
      line_q  <= 1'b0;
      en_q    <= 1'b0;
      col_q   <= 1'b0;
      rstep_q <= 1'b0;
      fs_q    <= 1'b0;
      pol_q   <= 1'b0;
      off_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      if (accept) begin
        first_q <= row_first_i;
        last_q  <= last_clamp;
        ts_q    <= t_setup_i;
        tg_q    <= t_gap_i;
        tw_q    <= t_lpw_i;
        line_q  <= line_inv_i;
        en_q    <= disp_en_i;
      end
      // strobes registered from next state so they align with st_q
      col_q   <= (st_d == ST_COLLD);
      rstep_q <= (st_d == ST_ROWST);
      fs_q    <= (st_d == ST_ROWST) && (row_d == '0);
      done_q  <= fin;
      off_q   <= (st_d != ST_IDLE) && (accept ? disp_en_i : en_q);
      if ((rstep_end && line_q) || (fin && !line_q)) pol_q <= ~pol_q;
    end
  end

  assign run_o      = (st_q == ST_SHIFT);
  assign row_o      = row_q;
  assign fstart_o   = fs_q;
  assign col_load_o = col_q;
  assign row_step_o = rstep_q;
  assign pol_o      = pol_q;
  assign off_no_o   = off_q;
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen #(
  parameter int ROWS  = 480,
  parameter int COLS  = 360,
  parameter int BUS_W = 4,
  parameter int TW    = 8,
  localparam int WORDS  = COLS / BUS_W,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_first_i,
  input  logic [ROW_W-1:0]  row_last_i,
  input  logic              disp_en_i,
  input  logic              line_inv_i,
  input  logic [TW-1:0]     t_setup_i,
  input  logic [TW-1:0]     t_gap_i,
  input  logic [TW-1:0]     t_lpw_i,
  output logic [ROW_W-1:0]  buf_row_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic              buf_rd_o,
  input  logic [BUS_W-1:0]  buf_data_i,
  output logic [BUS_W-1:0]  lcd_data_o,
  output logic              lcd_dclk_o,
  output logic              lcd_fstart_o,
  output logic              lcd_col_load_o,
  output logic              lcd_row_step_o,
  output logic              lcd_pol_o,
  output logic              lcd_off_no,
  output logic              busy_o,
  output logic              done_o
);
  logic run, shift_last;

  lcd_row_seq #(.ROWS(ROWS), .ROW_W(ROW_W), .TW(TW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .row_first_i  (row_first_i),
    .row_last_i   (row_last_i),
    .disp_en_i    (disp_en_i),
    .line_inv_i   (line_inv_i),
    .t_setup_i    (t_setup_i),
    .t_gap_i      (t_gap_i),
    .t_lpw_i      (t_lpw_i),
    .shift_last_i (shift_last),
    .run_o        (run),
    .row_o        (buf_row_o),
    .fstart_o     (lcd_fstart_o),
    .col_load_o   (lcd_col_load_o),
    .row_step_o   (lcd_row_step_o),
    .pol_o        (lcd_pol_o),
    .off_no_o     (lcd_off_no),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  lcd_word_shifter #(.BUS_W(BUS_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .buf_addr_o (buf_addr_o),
    .buf_rd_o   (buf_rd_o),
    .buf_data_i (buf_data_i),
    .data_o     (lcd_data_o),
    .dclk_o     (lcd_dclk_o),
    .last_o     (shift_last)
  );
endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk #(
  parameter int BUS_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [BUS_W-1:0] lcd_data_o,
  input logic             lcd_dclk_o,
  input logic             lcd_fstart_o,
  input logic             lcd_col_load_o,
  input logic             lcd_row_step_o,
  input logic             lcd_off_no,
  input logic             busy_o,
  input logic             done_o
);
  // R9
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R3
  dclk_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_dclk_o |-> busy_o);
  // R3
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_dclk_o) |-> $stable(lcd_data_o));
  // R7
  fstart_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_fstart_o |-> lcd_row_step_o);
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lcd_col_load_o && lcd_row_step_o));
  // R11
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !lcd_off_no);
  // R2
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind lcd_scan_gen lcd_scan_gen_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .lcd_data_o     (lcd_data_o),
  .lcd_dclk_o     (lcd_dclk_o),
  .lcd_fstart_o   (lcd_fstart_o),
  .lcd_col_load_o (lcd_col_load_o),
  .lcd_row_step_o (lcd_row_step_o),
  .lcd_off_no     (lcd_off_no),
  .busy_o         (busy_o),
  .done_o         (done_o)
);

// File: tb/tb_lcd_scan_gen.sv
module tb_lcd_scan_gen;
  localparam int ROWS = 480, COLS = 360, BUS_W = 4, TW = 8;
  localparam int WORDS = COLS / BUS_W;
  localparam int ROW_W = $clog2(ROWS);
  localparam int ADDR_W = $clog2(WORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start;
  logic [ROW_W-1:0]  row_first, row_last;
  logic              disp_en, line_inv;
  logic [TW-1:0]     t_setup, t_gap, t_lpw;
  logic [ROW_W-1:0]  buf_row;
  logic [ADDR_W-1:0] buf_addr;
  logic              buf_rd;
  logic [BUS_W-1:0]  buf_data;
  logic [BUS_W-1:0]  lcd_data;
  logic lcd_dclk, lcd_fstart, lcd_col_load, lcd_row_step, lcd_pol, lcd_off_n, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  int salt = 0;

  function automatic logic [BUS_W-1:0] pix(int r, int a, int s);
    int v;
    v = r * 13 + a * 5 + s + (r ^ (a >> 1));
    return BUS_W'(v);
  endfunction

  assign buf_data = pix(int'(buf_row), int'(buf_addr), salt);

  lcd_scan_gen #(.ROWS(ROWS), .COLS(COLS), .BUS_W(BUS_W), .TW(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .row_first_i(row_first), .row_last_i(row_last),
    .disp_en_i(disp_en), .line_inv_i(line_inv),
    .t_setup_i(t_setup), .t_gap_i(t_gap), .t_lpw_i(t_lpw),
    .buf_row_o(buf_row), .buf_addr_o(buf_addr), .buf_rd_o(buf_rd),
    .buf_data_i(buf_data), .lcd_data_o(lcd_data), .lcd_dclk_o(lcd_dclk),
    .lcd_fstart_o(lcd_fstart), .lcd_col_load_o(lcd_col_load),
    .lcd_row_step_o(lcd_row_step), .lcd_pol_o(lcd_pol), .lcd_off_no(lcd_off_n),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic run_update(input int first, input int last, input int ts, input int tg,
                            input int tw, input bit en, input bit line, input int inj_at);
    int lc, w, g, nd, dur;
    int cyc, busy_cyc, rs_cnt, cl_cnt, dclk_line, dclk_total, fs_rises, pol_chg, done_cnt;
    int e_data, e_shift, e_setup, e_tim, e_fs, e_off;
    int t_dfall, t_clr, t_clf, t_rsr, t_rsf;
    bit p_dclk, p_cl, p_rs, p_fs, p_pol, pol0, had_cl, fin;
    lc = (last > ROWS - 1) ? ROWS - 1 : last;
    w  = (tw == 0) ? 1 : tw;
    g  = (tg == 0) ? 1 : tg;
    nd = (first <= lc) ? lc - first + 1 : 0;
    dur = (lc + 1 - nd) * (g + w) + nd * (2 * WORDS + ts + 1 + w + g + w);
    cyc = 0; busy_cyc = 0; rs_cnt = 0; cl_cnt = 0; dclk_line = 0; dclk_total = 0;
    fs_rises = 0; pol_chg = 0; done_cnt = 0;
    e_data = 0; e_shift = 0; e_setup = 0; e_tim = 0; e_fs = 0; e_off = 0;
    t_dfall = -1000; t_clr = 0; t_clf = 0; t_rsr = 0; t_rsf = 0;
    had_cl = 0; fin = 0;
    salt = int'($urandom % 16);
    @(negedge clk);
    row_first = ROW_W'(first); row_last = ROW_W'(last);
    t_setup = TW'(ts); t_gap = TW'(tg); t_lpw = TW'(tw);
    disp_en = en; line_inv = line; start = 1'b1;
    pol0 = lcd_pol;
    p_dclk = 0; p_cl = 0; p_rs = 0; p_fs = 0; p_pol = pol0;
    @(negedge clk);
    start = 1'b0;
    for (int it = 0; it < 100000; it++) begin
      cyc++;
      if (busy) begin
        busy_cyc++;
        if (lcd_off_n != en) e_off++;
      end
      if (lcd_pol != p_pol) pol_chg++;
      if (lcd_dclk && !p_dclk) begin
        if (rs_cnt < first) e_data++;
        else if (lcd_data != pix(rs_cnt, dclk_line, salt)) e_data++;
        dclk_line++; dclk_total++;
      end
      if (!lcd_dclk && p_dclk) t_dfall = cyc;
      if (rs_cnt < first && lcd_data != '0) e_data++;
      if (lcd_col_load && !p_cl) begin
        cl_cnt++;
        if (dclk_line != WORDS) e_shift++;
        if (cyc - t_dfall != ts) e_setup++;
        t_clr = cyc; had_cl = 1;
      end
      if (!lcd_col_load && p_cl) begin
        if (cyc - t_clr != w) e_tim++;
        t_clf = cyc;
      end
      if (lcd_row_step && !p_rs) begin
        if (had_cl) begin
          if (cyc - t_clf != g) e_tim++;
        end else if (rs_cnt > 0) begin
          if (cyc - t_rsf != g) e_tim++;
        end
        t_rsr = cyc;
      end
      if (!lcd_row_step && p_rs) begin
        if (cyc - t_rsr != w) e_tim++;
        t_rsf = cyc; rs_cnt++; dclk_line = 0; had_cl = 0;
      end
      if (lcd_fstart && !p_fs) fs_rises++;
      if (lcd_fstart && !(lcd_row_step && rs_cnt == 0)) e_fs++;
      if (lcd_row_step && rs_cnt == 0 && !lcd_fstart) e_fs++;
      p_dclk = lcd_dclk; p_cl = lcd_col_load; p_rs = lcd_row_step;
      p_fs = lcd_fstart; p_pol = lcd_pol;
      if (done) begin
        done_cnt++;
        chk(lcd_off_n == 1'b0, "R11 off at done", int'(lcd_off_n), 0);
        fin = 1;
        break;
      end
      start = (it == inj_at);
      if (it == inj_at) begin
        row_first = '0; row_last = ROW_W'(3);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(fin, "R9 update completes", int'(fin), 1);
    chk(busy_cyc == dur, "R9 busy duration", busy_cyc, dur);
    chk(rs_cnt == lc + 1, "R8 row steps", rs_cnt, lc + 1);
    chk(cl_cnt == nd, "R8 column loads", cl_cnt, nd);
    chk(dclk_total == nd * WORDS, "R3 data clocks", dclk_total, nd * WORDS);
    chk(e_data == 0, "R3/R4 data words", e_data, 0);
    chk(e_shift == 0, "R3 clocks per row", e_shift, 0);
    chk(e_setup == 0, "R5 setup delay", e_setup, 0);
    chk(e_tim == 0, "R6 widths and gap", e_tim, 0);
    chk(e_fs == 0 && fs_rises == 1, "R7 frame start", fs_rises, 1);
    chk(pol_chg == (line ? lc + 1 : 1), "R10 polarity toggles", pol_chg, line ? lc + 1 : 1);
    chk(e_off == 0, "R11 display off level", e_off, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done && !busy, "R2/R9 no second pass", int'(done) + int'(busy), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    start = 1'b0; row_first = '0; row_last = '0; disp_en = 1'b0; line_inv = 1'b0;
    t_setup = '0; t_gap = '0; t_lpw = '0;
    repeat (3) @(negedge clk);
    // R1
    chk({busy, done, lcd_off_n, lcd_dclk, lcd_fstart, lcd_col_load, lcd_row_step, lcd_pol} == '0
        && lcd_data == '0, "R1 reset state",
        int'({busy, done, lcd_off_n, lcd_dclk, lcd_fstart, lcd_col_load, lcd_row_step, lcd_pol}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !lcd_off_n, "R1 idle after reset", int'(busy), 0);
    // directed corners
    run_update(0, 0, 0, 0, 0, 1'b1, 1'b0, -1);      // R5 zero settings, band at row 0
    run_update(5, 2, 1, 2, 1, 1'b0, 1'b1, -1);      // R4 all rows blank
    run_update(2, 4, 3, 1, 2, 1'b1, 1'b0, 20);      // R2 start while busy
    run_update(470, 479, 2, 2, 3, 1'b1, 1'b1, -1);  // band ends at last row
    run_update(477, 500, 1, 3, 1, 1'b0, 1'b0, -1);  // R2 clamp of last row
    for (int n = 0; n < 8; n++) begin
      run_update(int'($urandom % 10), int'($urandom % 14), int'($urandom % 5),
                 int'($urandom % 5), int'($urandom % 5), 1'($urandom % 2),
                 1'($urandom % 2), int'($urandom % 60));
    end
    summary();
    $finish;
  end
endmodule